// File: doc/BRIEF.md
# I2C Register-File Control Target

This block is the target side of a two-wire control port for a small bank of eight-bit configuration registers. A fast system clock oversamples the serial clock and data lines. The block finds START, repeated START and STOP conditions and answers a single 7-bit device address. The lowest bit of that address comes from a strap input, so two devices can share one bus. The block never drives a line high. It only asserts an output enable that pulls the data line low.

A write sets an internal register pointer and then stores data bytes into the bank at that pointer. A read sends whatever register the pointer selects. The pointer keeps its value between transactions. A flag carried in the pointer byte decides whether the pointer steps forward after every byte, which allows burst access, or stays on one register. The register bank sits behind a plain parallel read/write port inside the block.

Top module: `ctrl_i2c_regslave`

## Requirements
- R1: The device address is the 7-bit value 001100 followed by the strap input level. The address byte sends those seven bits MSB first, then the R/W bit, where 1 means read. A matching byte is acknowledged by pulling SDA low during the ninth clock. A non-matching byte is not acknowledged, and SDA stays released until the next START.
- R2: In a write, the first byte after the address loads the pointer. Bit 7 of that byte is the auto-increment flag and bits 6:0 are the register address. Every byte of a matched write is acknowledged.
- R3: Each further write byte is stored in the register the pointer selects. With the flag at 1, the pointer then advances by one, modulo 128. With the flag at 0, the pointer stays, so later bytes overwrite the same register.
- R4: In a matched read, the block sends the register the pointer selects, MSB first, starting with the clock that follows the address acknowledge.
- R5: In a read with the flag at 1, every controller ACK brings the next register in sequence. With the flag at 0, the same register is sent again.
- R6: The pointer and its flag keep their values across STOP and across later transactions. After reset the pointer holds address 0 with the flag at 0.
- R7: Registers exist at addresses 0 to 15. Any other address reads as 0x00, and a write to it changes no register.
- R8: After the controller NACKs a read byte, the block releases SDA and drives nothing until a START. Further clocks read as all ones.
- R9: A START or repeated START in any state restarts the address phase and discards any partial byte. After a STOP, bits clocked without a START get no response.
- R10: The SDA output enable changes only while SCL is low.
- R11: Reset clears every register to 0x00 and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Strap level that sets the lowest address bit |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
Some rules hold on every cycle, and assertions check them there. The output enable never moves while SCL is high. The pointer changes only when a byte completes. An acknowledge of the address needs a matching byte. A controller NACK is always followed by a released line. The bit counter never passes eight. Other behaviour depends on data, and only the bench's transaction sequences can show it. This covers the stored and returned values, how auto-increment steps through the bank and wraps past the top, pointer persistence across separate transactions, the zeros read from unused addresses, and the silence after a NACK, a mismatch or a STOP.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } i2cs_state_e;

    // pointer byte layout: auto-increment flag on top, register address below
    typedef struct packed {
        logic       incr;
        logic [6:0] addr;
    } map_t;

    // per-cycle bus view after synchronisation
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b,
                                       input logic [5:0] hi,
                                       input logic       strap);
        return (b[7:2] == hi) && (b[1] == strap);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_ff[STAGES-1];
            sda_p <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_p;
        ev.scl_fall = ~ev.scl & scl_p;
        ev.start    = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop     = ev.scl & scl_p & ~sda_p & ev.sda;
    end

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
    parameter int NUM_REGS = 16,
    parameter int AW       = 7,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int            IDXW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(NUM_REGS);

    logic [DW-1:0] mem [NUM_REGS];
    logic          in_range;
    logic [IDXW-1:0] idx;

    assign in_range = (addr < LIMIT);
    assign idx      = addr[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we && in_range) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = in_range ? mem[idx] : '0;

endmodule

// File: rtl/ctrl_i2c_regslave.sv
module ctrl_i2c_regslave
    import i2cs_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
    parameter logic [6:0] MAP_RESET   = 7'h00
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    output logic sda_oe_o
);
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS);

    bus_ev_t        ev;
    i2cs_state_e    state;
    logic [CW-1:0]  cnt;
    logic [7:0]     rx_sh;
    logic [7:0]     tx_sh;
    map_t           map;
    logic           first_byte;
    logic           mack;
    logic           bank_we;
    logic [7:0]     bank_rdata;
    logic           byte_done;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_regbank #(.NUM_REGS(NUM_REGS), .AW(7), .DW(8)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .addr  (map.addr),
        .wdata (rx_sh),
        .rdata (bank_rdata)
    );

    assign byte_done = ev.scl_fall && (cnt == LAST);
    assign bank_we   = (state == ST_WR_BYTE) && byte_done && !first_byte
                       && !ev.start && !ev.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            map        <= '{incr: 1'b0, addr: MAP_RESET};
            first_byte <= 1'b0;
            mack       <= 1'b0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR: begin
                    if (ev.scl_rise && cnt < LAST) begin
                        rx_sh <= {rx_sh[6:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt   <= '0;
                        state <= dev_match(rx_sh, DEV_ADDR_HI, addr_sel_i)
                                 ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rx_sh[0]) begin
                            state <= ST_RD_BYTE;
                            tx_sh <= bank_rdata;
                        end else begin
                            state      <= ST_WR_BYTE;
                            first_byte <= 1'b1;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (ev.scl_rise && cnt < LAST) begin
                        rx_sh <= {rx_sh[6:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt   <= '0;
                        state <= ST_WR_ACK;
                        if (first_byte) begin
                            map        <= map_t'(rx_sh);
                            first_byte <= 1'b0;
                        end else if (map.incr) begin
                            map.addr <= map.addr + 7'd1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev.scl_fall) begin
                        state <= ST_WR_BYTE;
                        cnt   <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (ev.scl_fall) begin
                        if (cnt == LAST - 1'b1) begin
                            state <= ST_RD_ACK;
                            cnt   <= '0;
                            if (map.incr) map.addr <= map.addr + 7'd1;
                        end else begin
                            tx_sh <= {tx_sh[6:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            state <= ST_RD_BYTE;
                            tx_sh <= bank_rdata;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = (state == ST_ADDR_ACK) || (state == ST_WR_ACK)
                    || ((state == ST_RD_BYTE) && !tx_sh[7]);

    // R10: output enable never moves while SCL stays high
    a_r10_oe_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && !ev.scl_rise) |-> $stable(sda_oe_o));

    // R6: pointer only moves at a byte boundary
    a_r6_map_holds: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_WR_BYTE || state == ST_RD_BYTE) |=> $stable(map));

    // R1: the address acknowledge needs a matching byte
    a_r1_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_ADDR_ACK) |-> dev_match(rx_sh, DEV_ADDR_HI, addr_sel_i));

    // R8: a controller NACK leaves the line released
    a_r8_quiet_after_nack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK && ev.scl_fall && !mack && !ev.start && !ev.stop)
        |=> !sda_oe_o);

    // R9: the bit counter stays within one byte
    a_r9_bitcnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: tb/ctrl_i2c_regslave_tb.sv
module ctrl_i2c_regslave_tb;

    localparam time Q  = 50ns;
    localparam int  WD = 150000;

    typedef struct {
        bit         is_ack;
        logic [7:0] val;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_low = 1'b0;
    logic strap = 1'b0;
    logic dut_oe;
    logic sda_line;

    always #5ns clk = ~clk;

    assign sda_line = !(sda_low || dut_oe);

    ctrl_i2c_regslave u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .addr_sel_i (strap),
        .sda_oe_o   (dut_oe)
    );

    int n_cmp = 0;
    int n_fail = 0;
    int r10_bad = 0;
    bit done = 0;

    item_t      exp_q[$];
    bit         obs_is_ack;
    logic [7:0] obs_val;
    event       obs_ev;

    logic [7:0] m_regs [16];
    logic [6:0] m_ptr;
    bit         m_inc;

    // scoreboard monitor
    initial begin : mon
        item_t e;
        forever begin
            @(obs_ev);
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected observation act=%h", obs_val);
            end else begin
                e = exp_q.pop_front();
                if (e.is_ack != obs_is_ack || e.val !== obs_val) begin
                    n_fail++;
                    $display("FAIL %s: %s act=%h exp=%h", e.tag,
                             e.is_ack ? "ack" : "data", obs_val, e.val);
                end
            end
        end
    end

    // R10: the design must change its enable only while SCL is low
    always @(dut_oe) if (!rst && scl_drv) r10_bad++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_low = 0; #Q; scl_drv = 1; #Q; sda_low = 1; #Q; scl_drv = 0; #Q;
    endtask

    task automatic bus_stop();
        sda_low = 1; #Q; scl_drv = 1; #Q; sda_low = 0; #Q; #Q;
    endtask

    task automatic put_bit(input bit b);
        sda_low = !b; #Q; scl_drv = 1; #Q; #Q; scl_drv = 0; #Q;
    endtask

    task automatic get_bit(output bit b);
        sda_low = 0; #Q; scl_drv = 1; #Q; b = sda_line; #Q; scl_drv = 0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string tag);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        exp_q.push_back('{is_ack: 1'b1, val: {7'd0, exp_ack}, tag: tag});
        obs_is_ack = 1'b1;
        obs_val    = {7'd0, !b};
        ->obs_ev;
        #1ns;
    endtask

    task automatic recv_byte(input bit ack, input logic [7:0] expv, input string tag);
        bit b;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ack);
        exp_q.push_back('{is_ack: 1'b0, val: expv, tag: tag});
        obs_is_ack = 1'b0;
        obs_val    = v;
        ->obs_ev;
        #1ns;
    endtask

    function automatic logic [7:0] a_w();
        return {6'b001100, strap, 1'b0};
    endfunction

    function automatic logic [7:0] a_r();
        return {6'b001100, strap, 1'b1};
    endfunction

    task automatic set_ptr_model(input logic [7:0] mapb);
        m_ptr = mapb[6:0];
        m_inc = mapb[7];
    endtask

    task automatic r_bytes(input int n, input string tag);
        logic [7:0] e;
        for (int k = 0; k < n; k++) begin
            e = (m_ptr < 7'd16) ? m_regs[m_ptr[3:0]] : 8'h00;
            recv_byte(k != n - 1, e, tag);
            if (m_inc) m_ptr = m_ptr + 7'd1;
        end
    endtask

    task automatic w_txn(input logic [7:0] mapb, input int n,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3,
                         input string tag);
        logic [7:0] dv [4];
        dv = '{d0, d1, d2, d3};
        bus_start();
        send_byte(a_w(), 1, tag);
        send_byte(mapb, 1, tag);
        set_ptr_model(mapb);
        for (int k = 0; k < n; k++) begin
            send_byte(dv[k], 1, tag);
            if (m_ptr < 7'd16) m_regs[m_ptr[3:0]] = dv[k];
            if (m_inc) m_ptr = m_ptr + 7'd1;
        end
        bus_stop();
    endtask

    task automatic r_txn(input int n, input string tag);
        bus_start();
        send_byte(a_r(), 1, tag);
        r_bytes(n, tag);
        bus_stop();
    endtask

    task automatic ptr_read(input logic [7:0] mapb, input int n, input string tag);
        bus_start();
        send_byte(a_w(), 1, tag);
        send_byte(mapb, 1, tag);
        set_ptr_model(mapb);
        bus_start();
        send_byte(a_r(), 1, tag);
        r_bytes(n, tag);
        bus_stop();
    endtask

    initial begin : wdog
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        m_ptr = 7'h00;
        m_inc = 0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(dut_oe == 1'b0, "R11 SDA released in reset", int'(dut_oe), 0);
        rst = 0;
        repeat (5) @(negedge clk);
        chk(sda_line == 1'b1, "R11 line idle after reset", int'(sda_line), 1);

        // default pointer and cleared bank
        r_txn(1, "R6 R11 read after reset");

        // foreign addresses
        bus_start();
        send_byte(8'h32, 0, "R1 strap bit mismatch NACK");
        send_byte(a_w(), 0, "R1 ignored until START");
        bus_stop();
        bus_start();
        send_byte(8'h50, 0, "R1 other address NACK");
        bus_stop();

        // burst write, then reads with both flag settings
        w_txn(8'h82, 4, 8'hA1, 8'hB2, 8'hC3, 8'hD4, "R2 R3 incr write");
        ptr_read(8'h02, 3, "R5 no-incr read repeats");
        ptr_read(8'h83, 3, "R4 R5 incr read");

        // pointer persistence
        w_txn(8'h05, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R2 pointer-only write");
        r_txn(1, "R6 pointer persists");
        r_txn(2, "R6 pointer persists again");

        // no-increment write overwrites one register
        w_txn(8'h07, 2, 8'h11, 8'h22, 8'h00, 8'h00, "R3 no-incr write");
        ptr_read(8'h86, 3, "R3 neighbours untouched");

        // top of the bank
        w_txn(8'h8F, 2, 8'h77, 8'h88, 8'h00, 8'h00, "R7 write past top");
        ptr_read(8'h8E, 4, "R7 out-of-range reads zero");
        w_txn(8'h20, 1, 8'h99, 8'h00, 8'h00, 8'h00, "R7 write far address");
        ptr_read(8'h20, 1, "R7 far address reads zero");
        ptr_read(8'h80, 16, "R7 bank unchanged by far writes");

        // controller NACK then extra clocks
        bus_start();
        send_byte(a_w(), 1, "R8 setup");
        send_byte(8'h82, 1, "R8 setup");
        set_ptr_model(8'h82);
        bus_start();
        send_byte(a_r(), 1, "R8 setup");
        r_bytes(1, "R8 last byte");
        recv_byte(0, 8'hFF, "R8 released after NACK");
        bus_stop();
        r_txn(1, "R8 pointer after NACK");

        // restart mid byte, then silence after STOP
        bus_start();
        send_byte(a_w(), 1, "R9 setup");
        send_byte(8'h89, 1, "R9 setup");
        set_ptr_model(8'h89);
        send_byte(8'h44, 1, "R9 setup");
        m_regs[9] = 8'h44;
        m_ptr = 7'd10;
        put_bit(1); put_bit(0); put_bit(1); put_bit(1);
        bus_start();
        send_byte(a_r(), 1, "R9 repeated START mid byte");
        r_bytes(1, "R9 partial byte discarded");
        bus_stop();
        send_byte(a_w(), 0, "R9 no response without START");
        bus_stop();

        // other strap level
        strap = 1;
        #Q;
        ptr_read(8'h09, 1, "R1 strap high address");
        bus_start();
        send_byte(8'h30, 0, "R1 strap-low address NACK");
        bus_stop();

        chk(r10_bad == 0, "R10 enable moved while SCL high", r10_bad, 0);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        done = 1;
        #100ns;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule